// File: doc/BRIEF.md
# Serial-Forwarding Bus Slave

This block is a bus slave that serves no storage of its own. Every read or write it accepts is packed into a short byte frame and streamed to a serial transmitter, so that a second system at the far end of the link carries out the access. A write frame is a command byte, the address bytes with the most significant byte first, and one data byte. A read frame has no data byte, and the far end answers it with a single byte on the receive stream.

A remote read can take a long time, so the slave releases the shared bus with a split. Internally a small port state machine passes through SPLIT, WAIT and DONE. The split seen by the bus stays high while a read is outstanding and its answer has not come back. The resume grant from the arbiter is also held away from the port state machine until that answer is present. Because of this, a resumed master always samples the real remote byte and never an empty register. Writes use the same split path and complete once their last byte has been handed to the transmitter. They wait for no acknowledgement.

The bus side uses a one-cycle request strobe with address, direction and write data, and the completion of the data phase is a one-cycle ready pulse. The transmit side is a valid/ready byte stream. The receive side is a byte strobe with no backpressure.

Top module: `sfwd_remote_slave`

## Requirements
- R1: While reset is high (asynchronous, active high) and in the first cycle after it falls, `bus_split`, `bus_ready` and `lnk_tx_valid` are low.
- R2: An accepted request produces exactly one frame, one byte per `lnk_tx_valid && lnk_tx_ready` cycle. The bytes are: a command byte whose bit 0 is 1 for write and 0 for read, with bits 7:1 zero; then the 16-bit address, high byte first; then, for writes only, the data byte. A read frame is 3 bytes long and a write frame is 4.
- R3: While `lnk_tx_valid` is high and `lnk_tx_ready` is low, the next cycle keeps `lnk_tx_valid` high with `lnk_tx_data` unchanged.
- R4: `bus_split` rises in the cycle after a request is accepted. For a write it falls in the cycle after the last frame byte's handshake.
- R5: For a read, `bus_split` stays high until the cycle after the response byte is received on `lnk_rx_valid`, even after the frame has been sent.
- R6: While a read response is outstanding, a high `bus_split_grant` does not produce `bus_ready`.
- R7: Once the frame is sent and, for a read, the response has arrived, `bus_ready` is high for exactly one cycle. That cycle is the one after the first clock edge at which `bus_split_grant` is sampled high. For reads, `bus_rdata` then equals the received response byte.
- R8: A write completes through R7 without any byte on the receive stream.
- R9: A request strobe that arrives while a transaction is in progress is ignored. It adds no frame bytes and no extra `bus_ready` pulse.
- R10: A receive byte that arrives while no read is outstanding is ignored. The next read still waits for its own response.
- R11: Asserting reset in the middle of a transaction abandons it, and the next request is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_req | input | 1 | One-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Request address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_ready |
| bus_ready | output | 1 | One-cycle data-phase completion |
| bus_split | output | 1 | Split: bus released while the remote side works |
| bus_split_grant | input | 1 | Resume grant from the arbiter |
| lnk_tx_data | output | 8 | Frame byte to the transmitter |
| lnk_tx_valid | output | 1 | Frame byte valid |
| lnk_tx_ready | input | 1 | Transmitter takes the byte |
| lnk_rx_data | input | 8 | Byte from the receiver |
| lnk_rx_valid | input | 1 | Receive byte strobe |

## Verification
Split rises one edge after the accepting edge. After the edge that hands over the last frame byte, split falls one cycle later for a write. For a read it stays high until one cycle after the edge that samples the response. Ready follows one cycle after the first edge that sees a usable grant. The bench drives every input half a period away from the active edge. It records handshakes at the same point, counts edges from each of these events, and checks the outputs at the exact cycle it has computed. During the waiting windows it checks on every cycle that split stays high and ready stays low.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int LINK_W = 8;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_SPLIT = 2'd1,
    PS_WAIT  = 2'd2,
    PS_DONE  = 2'd3
  } port_st_e;

  // Number of bytes in a request frame: command, address bytes, optional data.
  function automatic int frame_len(input logic wr, input int nab);
    return 1 + nab + (wr ? 1 : 0);
  endfunction

  // Byte at position idx of a request frame; address sent high byte first.
  function automatic logic [LINK_W-1:0] frame_byte(input int idx, input logic wr,
                                                   input logic [31:0] addr, input int nab,
                                                   input logic [LINK_W-1:0] data);
    logic [LINK_W-1:0] b;
    if (idx == 0)        b = {{(LINK_W-1){1'b0}}, wr};
    else if (idx <= nab) b = addr[LINK_W*(nab-idx) +: LINK_W];
    else                 b = data;
    return b;
  endfunction
endpackage

// File: rtl/sfwd_link_tx.sv
module sfwd_link_tx
  import sfwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LINK_W-1:0] data_in,
  output logic [LINK_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              done
);
  localparam int NAB    = ADDR_W / LINK_W;
  localparam int MAXLEN = NAB + 2;
  localparam int IW     = $clog2(MAXLEN + 1);

  logic              busy;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINK_W-1:0] data_q;
  logic [IW-1:0]     idx;
  logic              last;
  logic              hs;

  assign last     = (idx == IW'(frame_len(wr_q, NAB) - 1));
  assign hs       = busy & tx_ready;
  assign done     = hs & last;
  assign tx_valid = busy;
  assign tx_data  = frame_byte(int'(idx), wr_q, 32'(addr_q), NAB, data_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      idx    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx    <= '0;
      wr_q   <= wr_in;
      addr_q <= addr_in;
      data_q <= data_in;
    end else if (hs) begin
      if (last) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sfwd_rsp_cap.sv
module sfwd_rsp_cap
  import sfwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              finish,
  input  logic              rx_valid,
  input  logic [LINK_W-1:0] rx_data,
  output logic              rd_busy,
  output logic              rsp_got,
  output logic [LINK_W-1:0] rsp_byte
);
  logic take;
  assign take = rx_valid & rd_busy & ~rsp_got & ~finish;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rd_busy  <= 1'b0;
      rsp_got  <= 1'b0;
      rsp_byte <= '0;
    end else begin
      if (finish) begin
        rd_busy <= 1'b0;
        rsp_got <= 1'b0;
      end else if (rd_start) begin
        rd_busy <= 1'b1;
      end
      if (take) begin
        rsp_got  <= 1'b1;
        rsp_byte <= rx_data;
      end
    end
  end
endmodule

// File: rtl/sfwd_port_fsm.sv
module sfwd_port_fsm
  import sfwd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic link_done,
  input  logic grant,
  output logic accept,
  output logic sp_split,
  output logic phase_done
);
  port_st_e st, st_nx;

  assign accept     = (st == PS_IDLE) & req;
  assign sp_split   = (st == PS_SPLIT);
  assign phase_done = (st == PS_DONE);

  always_comb begin
    st_nx = st;
    unique case (st)
      PS_IDLE:  if (req)       st_nx = PS_SPLIT;
      PS_SPLIT: if (link_done) st_nx = PS_WAIT;
      PS_WAIT:  if (grant)     st_nx = PS_DONE;
      PS_DONE:                 st_nx = PS_IDLE;
      default:                 st_nx = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) st <= PS_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/sfwd_remote_slave.sv
module sfwd_remote_slave
  import sfwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINK_W-1:0] bus_wdata,
  output logic [LINK_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_split,
  input  logic              bus_split_grant,
  output logic [LINK_W-1:0] lnk_tx_data,
  output logic              lnk_tx_valid,
  input  logic              lnk_tx_ready,
  input  logic [LINK_W-1:0] lnk_rx_data,
  input  logic              lnk_rx_valid
);
  // Named internal events, visible to the bound checker.
  logic accept;
  logic link_done;
  logic sp_split;
  logic sp_grant;
  logic rd_busy;
  logic rsp_got;
  logic rd_pending;

  assign rd_pending = rd_busy & ~rsp_got;
  assign bus_split  = sp_split | rd_pending;
  assign sp_grant   = rd_busy ? (bus_split_grant & rsp_got) : bus_split_grant;

  sfwd_port_fsm u_port (
    .clk        (clk),
    .rst        (rst),
    .req        (bus_req),
    .link_done  (link_done),
    .grant      (sp_grant),
    .accept     (accept),
    .sp_split   (sp_split),
    .phase_done (bus_ready)
  );

  sfwd_link_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .wr_in    (bus_we),
    .addr_in  (bus_addr),
    .data_in  (bus_wdata),
    .tx_data  (lnk_tx_data),
    .tx_valid (lnk_tx_valid),
    .tx_ready (lnk_tx_ready),
    .done     (link_done)
  );

  sfwd_rsp_cap u_rsp (
    .clk      (clk),
    .rst      (rst),
    .rd_start (accept & ~bus_we),
    .finish   (bus_ready),
    .rx_valid (lnk_rx_valid),
    .rx_data  (lnk_rx_data),
    .rd_busy  (rd_busy),
    .rsp_got  (rsp_got),
    .rsp_byte (bus_rdata)
  );
endmodule

// File: rtl/sfwd_remote_slave_chk.sv
module sfwd_remote_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_ready,
  input logic       bus_split,
  input logic [7:0] lnk_tx_data,
  input logic       lnk_tx_valid,
  input logic       lnk_tx_ready,
  input logic       rd_pending
);
  always @(posedge clk) begin
    if (rst) begin
      a_r1_reset_quiet: assert (!bus_split && !bus_ready && !lnk_tx_valid);
    end
  end

  a_r2_cmd_first: assert property (@(posedge clk) disable iff (rst)
    $rose(lnk_tx_valid) |-> (lnk_tx_data[7:1] == 7'd0));

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (lnk_tx_valid && !lnk_tx_ready) |=> (lnk_tx_valid && $stable(lnk_tx_data)));

  a_r6_no_empty_resume: assert property (@(posedge clk) disable iff (rst)
    rd_pending |=> !bus_ready);

  a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  a_r5_split_off_at_data: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> !bus_split);
endmodule

bind sfwd_remote_slave sfwd_remote_slave_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_ready    (bus_ready),
  .bus_split    (bus_split),
  .lnk_tx_data  (lnk_tx_data),
  .lnk_tx_valid (lnk_tx_valid),
  .lnk_tx_ready (lnk_tx_ready),
  .rd_pending   (rd_pending)
);

// File: tb/sfwd_remote_slave_tb.sv
`timescale 1ns/1ps
module sfwd_remote_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_split_grant = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, lnk_rx_data = '0;
  logic        lnk_rx_valid = 1'b0, lnk_tx_ready = 1'b0;
  logic [7:0]  bus_rdata, lnk_tx_data;
  logic        bus_ready, bus_split, lnk_tx_valid;

  always #10 clk = ~clk;  // 50 MHz

  sfwd_remote_slave u_dut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  bit done_flag = 0;
  bit sink_en = 0;
  int ready_pct = 100;
  logic [7:0] txq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      finish_run();
    end
  end

  // Expected frame, written independently of the design.
  function automatic int exp_len(input bit wr);
    return wr ? 4 : 3;
  endfunction
  function automatic logic [7:0] exp_byte(input int k, input bit wr, input logic [15:0] a, input logic [7:0] d);
    case (k)
      0: return wr ? 8'h01 : 8'h00;
      1: return a[15:8];
      2: return a[7:0];
      default: return d;
    endcase
  endfunction

  // Transmit sink: random backpressure, records each handshake.
  logic pv = 0, pr = 0;
  logic [7:0] pd = 0;
  always @(negedge clk) begin
    if (rst || !sink_en) begin
      pv = 0;
      lnk_tx_ready = 0;
    end else begin
      if (pv && !pr)  // R3
        chk(lnk_tx_valid && lnk_tx_data == pd, "R3 hold", {lnk_tx_valid, lnk_tx_data}, {1'b1, pd});
      lnk_tx_ready = ($urandom_range(99) < ready_pct);
      if (lnk_tx_valid && lnk_tx_ready) txq.push_back(lnk_tx_data);
      pv = lnk_tx_valid; pr = lnk_tx_ready; pd = lnk_tx_data;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_frame(input int n);
    for (int t = 0; t < 200 && txq.size() < n; t++) step();
  endtask

  // One transaction; gdly = cycles grant is held off after data is ready.
  task automatic txn(input bit wr, input logic [15:0] a, input logic [7:0] d,
                     input logic [7:0] rsp, input int dly, input int gdly, input bit intrude);
    int n = exp_len(wr);
    txq.delete();
    bus_split_grant = (gdly == 0);
    bus_req = 1; bus_we = wr; bus_addr = a; bus_wdata = d;
    step();
    bus_req = 0;
    chk(bus_split, "R4 split rise", bus_split, 1);
    wait_frame(n);
    chk(txq.size() == n, "R2 frame length", txq.size(), n);
    for (int k = 0; k < n && k < txq.size(); k++)
      chk(txq[k] == exp_byte(k, wr, a, d), "R2 frame byte", txq[k], exp_byte(k, wr, a, d));
    if (!wr) begin
      for (int i = 0; i < dly; i++) begin
        step();
        if (intrude && i == 0) begin bus_req = 1; bus_we = 1; bus_addr = 16'hBEEF; end
        if (intrude && i == 1) bus_req = 0;
        chk(bus_split, "R5 split held", bus_split, 1);
        chk(!bus_ready, "R6 no resume before data", bus_ready, 0);
      end
      bus_req = 0;
      lnk_rx_valid = 1; lnk_rx_data = rsp;
      step();
      lnk_rx_valid = 0;
      chk(!bus_split, "R5 split release", bus_split, 0);
      chk(!bus_ready, "R7 ready timing", bus_ready, 0);
    end else begin
      step();
      chk(!bus_split, "R4 write split fall", bus_split, 0);
      chk(!bus_ready, "R8 ready timing", bus_ready, 0);
    end
    for (int g = 0; g < gdly; g++) begin
      step();
      chk(!bus_ready, "R7 waits for grant", bus_ready, 0);
    end
    bus_split_grant = 1;
    step();
    chk(bus_ready, wr ? "R8 write done" : "R7 ready", bus_ready, 1);
    if (!wr) chk(bus_rdata == rsp, "R7 read data", bus_rdata, rsp);
    step();
    chk(!bus_ready, "R7 single pulse", bus_ready, 0);
    bus_split_grant = 0;
    for (int i = 0; i < 3; i++) step();
    chk(txq.size() == n, "R9 no extra frame", txq.size(), n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #25;
    chk(!bus_split && !bus_ready && !lnk_tx_valid, "R1 in reset", {bus_split, bus_ready, lnk_tx_valid}, 0);
    @(negedge clk); rst = 0; sink_en = 1;
    step();
    chk(!bus_split && !bus_ready && !lnk_tx_valid, "R1 after reset", {bus_split, bus_ready, lnk_tx_valid}, 0);

    // Directed corners
    txn(1'b0, 16'h1234, 8'h00, 8'hA5, 4, 0, 0);  // R5 R6 R7
    txn(1'b1, 16'h2FFE, 8'h5A, 8'h00, 0, 0, 0);  // R8
    txn(1'b0, 16'h0000, 8'h00, 8'h00, 1, 3, 0);  // R7 grant held off, zero data
    txn(1'b0, 16'hFFFF, 8'h00, 8'h7E, 3, 0, 1);  // R9 intruding request
    ready_pct = 100;
    // R10: stray receive byte while idle
    lnk_rx_valid = 1; lnk_rx_data = 8'h3C; step(); lnk_rx_valid = 0;
    chk(!bus_split && !bus_ready, "R10 stray rx idle", {bus_split, bus_ready}, 0);
    txn(1'b0, 16'h2001, 8'h00, 8'hC3, 3, 0, 0);  // R10 read still waits

    // R11: reset in mid-read
    txq.delete();
    bus_req = 1; bus_we = 0; bus_addr = 16'h0400; step(); bus_req = 0;
    wait_frame(3); step();
    chk(bus_split, "R11 busy before reset", bus_split, 1);
    rst = 1; #1;
    chk(!bus_split && !bus_ready && !lnk_tx_valid, "R11 reset abandons", {bus_split, bus_ready, lnk_tx_valid}, 0);
    step(); rst = 0; step();
    txn(1'b1, 16'h0401, 8'h99, 8'h00, 0, 0, 0);  // R11 next request served

    // Constrained random
    ready_pct = 60;
    for (int i = 0; i < 40; i++) begin
      bit wr = $urandom_range(1);
      txn(wr, 16'($urandom), 8'($urandom), 8'($urandom),
          1 + $urandom_range(5), $urandom_range(2), 0);
    end
    finish_run();
  end
endmodule